// File: doc/BRIEF.md
# Dual-Port SRAM Write Strobe Sequencer

This block sits between a synchronous request source and one port of an external asynchronous dual-port static RAM. It takes a single-cycle write request, made of an address, a data word, a target choice (memory array or semaphore cell), a timing-style bit and an output-enable choice. It turns that request into a write cycle on the RAM pins whose intervals are all whole clock cycles. Each interval length is a parameter: address setup, write-pulse width, enable-pulse width, output turn-off, data setup, data hold and write recovery.

Two strobe styles are supported. In the R/W-led style the selected enable falls first and R/W falls last, so R/W sets the overlap. In the enable-led style R/W falls first and the enable falls last, so the enable sets the overlap and the RAM outputs never turn on. When output enable is kept low during an R/W-led write, the overlap is stretched. The data driver also waits, so the RAM's own output drivers can turn off before the bus is driven. Only one write is in flight at a time, and the handshake's ready signal shows when the next request can be taken.

Top module: `dpram_wr_seq`

## Requirements
- R1: After reset and while idle, `mem_ce_n`, `mem_sem_n`, `mem_rw_n` and `mem_oe_n` are 1, `mem_drv_en` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the recovery interval ends. `req_valid` while `req_ready` is 0 is ignored: no new cycle starts and `mem_addr` keeps the last accepted address.
- R3: `mem_addr` takes the accepted address in the first cycle of the write and never changes while the selected enable and `mem_rw_n` are both low.
- R4: `req_sem`=0 selects the array: `mem_ce_n` goes low and `mem_sem_n` stays high. `req_sem`=1 selects the semaphore: `mem_sem_n` goes low and `mem_ce_n` stays high. The two are never low together.
- R5: With `req_ce_mode`=0 (R/W-led), the selected enable is low from the first cycle of the write, and `mem_rw_n` falls T_AS cycles later.
- R6: In R/W-led mode the overlap of enable low and `mem_rw_n` low lasts T_WP cycles with `req_oe_low`=0, and max(T_WP, T_WZ+T_DW) cycles with `req_oe_low`=1.
- R7: With `req_ce_mode`=1 (enable-led), `mem_rw_n` is low from the first cycle of the write. The selected enable falls T_AS cycles later and stays low for T_EW cycles.
- R8: In R/W-led mode with `req_oe_low`=1, `mem_drv_en` rises T_WZ cycles after `mem_rw_n` falls. In every other case it is 1 from the first cycle of the write. While it is 1, `mem_dq` carries the accepted data.
- R9: The enable and `mem_rw_n` both return high together at the end of the overlap. `mem_drv_en` falls T_DH cycles later. `req_ready` returns max(T_WR, T_DH) cycles after the overlap ends.
- R10: `mem_oe_n` is low for the whole write when `req_oe_low`=1, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_sem | input | 1 | 1 = semaphore cell, 0 = memory array |
| req_ce_mode | input | 1 | 1 = enable-led strobe, 0 = R/W-led strobe |
| req_oe_low | input | 1 | 1 = hold output enable low during the write |
| mem_addr | output | AW | RAM address |
| mem_dq | inout | DW | RAM data bus, released when not driven |
| mem_drv_en | output | 1 | Data bus driver enable |
| mem_ce_n | output | 1 | Array chip enable, active low |
| mem_sem_n | output | 1 | Semaphore enable, active low |
| mem_rw_n | output | 1 | Read/write, low = write |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
Writes are tried in every combination of target (array or semaphore), strobe style and output-enable choice. The R/W-led cases with output enable low and with output enable high differ in overlap length and driver delay. The two strobe styles differ in which pin falls first. The two targets differ in which enable moves. Back-to-back requests with all-ones and all-zeros address and data show that the address is held and the data byte is carried. A request raised while a write is in progress shows that it leaves no trace.

// File: rtl/dpwr_pkg.sv
package dpwr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RECOVER = 2'd3
   } phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned min2(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/dpwr_phase_timer.sv
module dpwr_phase_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else          count <= count + 1'b1;
   end
endmodule

// File: rtl/dpwr_req_reg.sv
module dpwr_req_reg #(
   parameter int unsigned AW = 13,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic          in_sem,
   input  logic          in_ce_mode,
   input  logic          in_oe_low,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data,
   output logic          q_sem,
   output logic          q_ce_mode,
   output logic          q_oe_low
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr    <= '0;
         q_data    <= '0;
         q_sem     <= 1'b0;
         q_ce_mode <= 1'b0;
         q_oe_low  <= 1'b0;
      end else if (load) begin
         q_addr    <= in_addr;
         q_data    <= in_data;
         q_sem     <= in_sem;
         q_ce_mode <= in_ce_mode;
         q_oe_low  <= in_oe_low;
      end
   end
endmodule

// File: rtl/dpwr_pin_decode.sv
module dpwr_pin_decode
   import dpwr_pkg::*;
#(
   parameter int unsigned CW   = 4,
   parameter int unsigned T_WZ = 1,
   parameter int unsigned T_DH = 1
) (
   input  phase_e        phase,
   input  logic [CW-1:0] count,
   input  logic          sel_sem,
   input  logic          ce_mode,
   input  logic          oe_low,
   output logic          ce_n,
   output logic          sem_n,
   output logic          rw_n,
   output logic          oe_n,
   output logic          drv_en
);
   localparam logic [CW-1:0] C_WZ = CW'(T_WZ);
   localparam logic [CW-1:0] C_DH = CW'(T_DH);

   logic busy, early, strobe, en_low, rw_low, wz_wait;

   always_comb begin
      busy    = (phase != PH_IDLE);
      strobe  = (phase == PH_STROBE);
      early   = (phase == PH_SETUP) || strobe;
      // the leading pin covers setup and strobe, the trailing pin only the strobe
      en_low  = ce_mode ? strobe : early;
      rw_low  = ce_mode ? early  : strobe;
      wz_wait = oe_low && !ce_mode;
      ce_n    = !(en_low && !sel_sem);
      sem_n   = !(en_low &&  sel_sem);
      rw_n    = !rw_low;
      oe_n    = !(oe_low && busy);
      unique case (phase)
         PH_SETUP:   drv_en = !wz_wait;
         PH_STROBE:  drv_en = !wz_wait || (count >= C_WZ);
         PH_RECOVER: drv_en = (count < C_DH);
         default:    drv_en = 1'b0;
      endcase
   end
endmodule

// File: rtl/dpram_wr_seq.sv
module dpram_wr_seq
   import dpwr_pkg::*;
#(
   parameter int unsigned AW   = 13,
   parameter int unsigned DW   = 8,
   parameter int unsigned T_AS = 2,
   parameter int unsigned T_WP = 3,
   parameter int unsigned T_EW = 4,
   parameter int unsigned T_WZ = 2,
   parameter int unsigned T_DW = 3,
   parameter int unsigned T_DH = 1,
   parameter int unsigned T_WR = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_sem,
   input  logic          req_ce_mode,
   input  logic          req_oe_low,
   output logic [AW-1:0] mem_addr,
   inout  wire  [DW-1:0] mem_dq,
   output logic          mem_drv_en,
   output logic          mem_ce_n,
   output logic          mem_sem_n,
   output logic          mem_rw_n,
   output logic          mem_oe_n
);
   // derived interval lengths, all in clock cycles
   localparam int unsigned PW_WZ  = max2(T_WP, T_WZ + T_DW);
   localparam int unsigned REC    = max2(T_WR, T_DH);
   localparam int unsigned PW_MIN = min2(T_WP, T_EW);
   localparam int unsigned MAXLEN = max2(max2(max2(T_AS, PW_WZ), max2(T_EW, REC)), T_WZ + 1);
   localparam int unsigned CW     = bits_for(MAXLEN + 1);

   localparam logic [CW-1:0] L_AS  = CW'(T_AS - 1);
   localparam logic [CW-1:0] L_WP  = CW'(T_WP - 1);
   localparam logic [CW-1:0] L_EW  = CW'(T_EW - 1);
   localparam logic [CW-1:0] L_PWZ = CW'(PW_WZ - 1);
   localparam logic [CW-1:0] L_REC = CW'(REC - 1);

   // elaboration-time parameter checks
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("dpram_wr_seq: AW and DW must be at least 1");
   end
   if (T_AS < 1 || T_WP < 1 || T_EW < 1 || T_WZ < 1 ||
       T_DW < 1 || T_DH < 1 || T_WR < 1) begin : g_bad_timing
      $error("dpram_wr_seq: every interval must be at least one cycle");
   end
   if (T_DW > T_AS + PW_MIN) begin : g_bad_setup
      $error("dpram_wr_seq: T_DW exceeds the earliest-driven data window");
   end

   phase_e        phase, phase_nx;
   logic [CW-1:0] count;
   logic          accept;
   logic [DW-1:0] q_data;
   logic          q_sem, q_ce_mode, q_oe_low;
   logic [CW-1:0] strobe_last;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   dpwr_req_reg #(.AW(AW), .DW(DW)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .in_addr    (req_addr),
      .in_data    (req_data),
      .in_sem     (req_sem),
      .in_ce_mode (req_ce_mode),
      .in_oe_low  (req_oe_low),
      .q_addr     (mem_addr),
      .q_data     (q_data),
      .q_sem      (q_sem),
      .q_ce_mode  (q_ce_mode),
      .q_oe_low   (q_oe_low)
   );

   always_comb begin
      if (q_ce_mode)     strobe_last = L_EW;
      else if (q_oe_low) strobe_last = L_PWZ;
      else               strobe_last = L_WP;
   end

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:    if (req_valid)            phase_nx = PH_SETUP;
         PH_SETUP:   if (count == L_AS)        phase_nx = PH_STROBE;
         PH_STROBE:  if (count == strobe_last) phase_nx = PH_RECOVER;
         PH_RECOVER: if (count == L_REC)       phase_nx = PH_IDLE;
         default:                              phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

   dpwr_phase_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_nx != phase),
      .count (count)
   );

   dpwr_pin_decode #(.CW(CW), .T_WZ(T_WZ), .T_DH(T_DH)) u_pins (
      .phase   (phase),
      .count   (count),
      .sel_sem (q_sem),
      .ce_mode (q_ce_mode),
      .oe_low  (q_oe_low),
      .ce_n    (mem_ce_n),
      .sem_n   (mem_sem_n),
      .rw_n    (mem_rw_n),
      .oe_n    (mem_oe_n),
      .drv_en  (mem_drv_en)
   );

   assign mem_dq = mem_drv_en ? q_data : {DW{1'bz}};

   // ---------------------------------------------------------------
   // assertions guarding the pin sequence
   // ---------------------------------------------------------------
   logic          en_any_n, ovl, ovl_q;
   logic [CW-1:0] ovl_len;

   assign en_any_n = mem_ce_n && mem_sem_n;
   assign ovl      = !en_any_n && !mem_rw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_q   <= 1'b0;
         ovl_len <= '0;
      end else begin
         ovl_q   <= ovl;
         ovl_len <= ovl ? ovl_len + 1'b1 : '0;
      end
   end

   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_sem_n && mem_rw_n && mem_oe_n && !mem_drv_en));

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl && ovl_q) |-> $stable(mem_addr));

   assert_one_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_ce_n && !mem_sem_n));

   assert_rw_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_rw_n) && !q_ce_mode) |-> $past(!en_any_n));

   assert_pulse_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_q && !ovl) |-> (ovl_len >= CW'(PW_MIN)));

   assert_enable_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_any_n) && q_ce_mode) |-> $past(!mem_rw_n));

   assert_joint_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_q && !ovl) |-> (en_any_n && mem_rw_n));

endmodule

// File: tb/dpram_wr_seq_tb_top.sv
module dpram_wr_seq_tb_top;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int T_AS = 2, T_WP = 3, T_EW = 4, T_WZ = 2, T_DW = 3, T_DH = 1, T_WR = 2;
   localparam int PWZ = (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;
   localparam int REC = (T_WR > T_DH) ? T_WR : T_DH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_sem = 1'b0, req_ce_mode = 1'b0, req_oe_low = 1'b0;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;
   logic          mem_drv_en, mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n;

   always #10 clk = ~clk;

   dpram_wr_seq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_EW(T_EW),
                  .T_WZ(T_WZ), .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_sem(req_sem),
      .req_ce_mode(req_ce_mode), .req_oe_low(req_oe_low), .mem_addr(mem_addr),
      .mem_dq(mem_dq), .mem_drv_en(mem_drv_en), .mem_ce_n(mem_ce_n),
      .mem_sem_n(mem_sem_n), .mem_rw_n(mem_rw_n), .mem_oe_n(mem_oe_n));

   int n_chk = 0, n_fail = 0, n_cycles = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      bit sem, ce_mode, oe_low;
      int pw, en_t, rw_t, drv_on, drv_off, rdy_t;
   } exp_t;
   exp_t exp_q[$];

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit sem, input bit cem, input bit oel);
      exp_t e;
      e.addr = a; e.data = d; e.sem = sem; e.ce_mode = cem; e.oe_low = oel;
      e.pw      = cem ? T_EW : (oel ? PWZ : T_WP);
      e.en_t    = cem ? T_AS : 0;
      e.rw_t    = cem ? 0 : T_AS;
      e.drv_on  = (oel && !cem) ? T_AS + T_WZ : 0;
      e.drv_off = T_AS + e.pw + T_DH;
      e.rdy_t   = T_AS + e.pw + REC;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_data = d; req_sem = sem; req_ce_mode = cem; req_oe_low = oel;
      req_valid = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: measures each write cycle on the pins and compares with the queue
   bit inc = 1'b0;
   int t, en_t, rw_t, ov_start, ov_len, drv_on, drv_off;
   bit ce_seen, sem_seen, oe_seen, moved;
   logic [AW-1:0] start_addr, ov_addr;
   logic [DW-1:0] ov_data;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (!inc && !req_ready) begin
            inc = 1'b1; t = 0; en_t = -1; rw_t = -1; ov_start = -1; ov_len = 0;
            drv_on = -1; drv_off = -1; ce_seen = 0; sem_seen = 0; oe_seen = 0;
            moved = 0; start_addr = mem_addr;
         end
         if (inc) begin
            if (mem_addr != start_addr) moved = 1;
            if ((!mem_ce_n || !mem_sem_n) && en_t < 0) en_t = t;
            if (!mem_rw_n && rw_t < 0) rw_t = t;
            if (!mem_ce_n) ce_seen = 1;
            if (!mem_sem_n) sem_seen = 1;
            if (!mem_oe_n) oe_seen = 1;
            if ((!mem_ce_n || !mem_sem_n) && !mem_rw_n) begin
               if (ov_start < 0) ov_start = t;
               ov_len++; ov_addr = mem_addr; ov_data = mem_dq;
            end
            if (mem_drv_en && drv_on < 0) drv_on = t;
            if (!mem_drv_en && drv_on >= 0 && drv_off < 0) drv_off = t;
            if (req_ready) begin
               inc = 1'b0;
               n_cycles++;
               if (exp_q.size() == 0) begin
                  chk(0, "R2 unexpected write cycle", 1, 0);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(ov_addr == e.addr && !moved, "R3 address in overlap", int'(ov_addr), int'(e.addr));
                  chk(ce_seen == !e.sem, "R4 array enable used", ce_seen, !e.sem);
                  chk(sem_seen == e.sem, "R4 semaphore enable used", sem_seen, e.sem);
                  if (!e.ce_mode) begin
                     chk(en_t == e.en_t, "R5 enable fall time", en_t, e.en_t);
                     chk(rw_t == e.rw_t, "R5 rw fall time", rw_t, e.rw_t);
                     chk(ov_len == e.pw, "R6 overlap length", ov_len, e.pw);
                  end else begin
                     chk(rw_t == e.rw_t, "R7 rw fall time", rw_t, e.rw_t);
                     chk(en_t == e.en_t, "R7 enable fall time", en_t, e.en_t);
                     chk(ov_len == e.pw, "R7 overlap length", ov_len, e.pw);
                  end
                  chk(drv_on == e.drv_on, "R8 driver on time", drv_on, e.drv_on);
                  chk(ov_data == e.data, "R8 data on bus", int'(ov_data), int'(e.data));
                  chk(drv_off == e.drv_off, "R9 driver off time", drv_off, e.drv_off);
                  chk(t == e.rdy_t, "R9 ready return time", t, e.rdy_t);
                  chk(ov_start == T_AS, "R9 overlap start", ov_start, T_AS);
                  chk(oe_seen == e.oe_low, "R10 output enable", oe_seen, e.oe_low);
               end
            end else begin
               t++;
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(mem_ce_n && mem_sem_n && mem_rw_n && mem_oe_n, "R1 strobes high",
          {mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n}, 15);
      chk(mem_drv_en == 1'b0, "R1 driver released", mem_drv_en, 0);

      send(13'h0123, 8'h5A, 0, 0, 0);
      send(13'h0456, 8'hA5, 0, 0, 1);
      send(13'h0789, 8'h3C, 1, 0, 0);
      send(13'h0ABC, 8'hC3, 1, 1, 0);
      send(13'h0DEF, 8'h96, 0, 1, 1);
      send(13'h1234, 8'h69, 1, 0, 1);
      send(13'h1FFF, 8'h00, 0, 0, 0);
      send(13'h0000, 8'hFF, 1, 1, 1);

      // R2: request raised while busy must leave no trace
      send(13'h0111, 8'h11, 0, 0, 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      req_addr = 13'h0AAA; req_data = 8'hEE; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0 || inc) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(mem_addr == 13'h0111, "R2 address after ignored request", int'(mem_addr), 'h111);
      chk(req_ready && mem_ce_n && mem_sem_n && mem_rw_n, "R2 idle after ignored request",
          req_ready, 1);
      chk(n_cycles == 9, "R2 write cycle count", n_cycles, 9);
      finish_run();
   end
endmodule